// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is a parameterised universal shift register meant to sit between a serial host link and a parallel data bus. On every rising clock edge it does one of four things, chosen by two mode-select inputs: keeps its contents, shifts toward the high end, shifts toward the low end, or loads a whole word from the parallel pins. A host can clock a byte in serially and then place it on the bus. It can also capture a byte from the bus and clock it back out serially.

The parallel pins are a single bidirectional group. When both active-low enables are asserted and the block is not loading, the pins show the register contents. In every other case the pins are released, so an external device can drive them. In load mode this released state lets the block sample the external word. The lowest and highest stages always appear on two dedicated serial outputs, so several blocks can be chained into longer words. An active-low clear acts at once, with no clock, and zeroes every stage.

Top module: `usr_shift_bridge`

## Requirements
- R1: While `clr_n` is low, all stages are zero at once, without waiting for a clock edge and whatever the mode. The contents stay zero until `clr_n` returns high.
- R2: With {`sel_hi`,`sel_lo`} = 2'b00 (hold), a rising edge leaves every stage unchanged.
- R3: With {`sel_hi`,`sel_lo`} = 2'b01 (shift up), a rising edge moves each bit i to bit i+1 and writes `ser_up_in` into bit 0.
- R4: With {`sel_hi`,`sel_lo`} = 2'b10 (shift down), a rising edge moves each bit i to bit i-1 and writes `ser_dn_in` into bit WIDTH-1.
- R5: With {`sel_hi`,`sel_lo`} = 2'b11 (load), a rising edge copies the value present on `io_bus` into the register. Bit i of the bus goes to bit i.
- R6: When `oe_a_n` and `oe_b_n` are both low and the mode is not load, `io_bus` bit i carries register bit i.
- R7: When `oe_a_n` or `oe_b_n` is high, the block releases `io_bus` to high impedance.
- R8: In load mode the block releases `io_bus`, even if both enables are low.
- R9: `q_lo` always equals register bit 0 and `q_hi` always equals bit WIDTH-1, whatever the state of the output enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel_hi | input | 1 | Mode select, upper bit |
| sel_lo | input | 1 | Mode select, lower bit |
| oe_a_n | input | 1 | Bus output enable A, active low |
| oe_b_n | input | 1 | Bus output enable B, active low |
| ser_up_in | input | 1 | Serial input that enters bit 0 during a shift up |
| ser_dn_in | input | 1 | Serial input that enters the top bit during a shift down |
| io_bus | inout | WIDTH | Parallel pins: register output, or load input |
| q_lo | output | 1 | Serial output from bit 0 |
| q_hi | output | 1 | Serial output from bit WIDTH-1 |

## Verification
The bench builds the block with WIDTH set to 4. At that width the sweep can cover every start value, every mode and every pair of serial-input levels. For each combination it compares the outcome with shift and mask arithmetic done in the bench. The narrow word also keeps the end bits, where the serial inputs enter and the serial outputs are taken, within a few shifts. High impedance is detected by driving the bus from the bench with a word different from the register and reading that word back. The clear is applied in the middle of a cycle to show that it acts without a clock edge.

// File: rtl/usr_pkg.sv
package usr_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;

endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
  import usr_pkg::*;
(
  input  logic      sel_hi,
  input  logic      sel_lo,
  input  logic      oe_a_n,
  input  logic      oe_b_n,
  output usr_mode_e mode,
  output logic      drive_en
);

  always_comb begin
    mode = usr_mode_e'({sel_hi, sel_lo});
  end

  // Pins are driven only when both enables are active and no load is pending.
  always_comb begin
    drive_en = !oe_a_n && !oe_b_n && (mode != MODE_LOAD);
  end

endmodule

// File: rtl/usr_stage_array.sv
module usr_stage_array
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  usr_mode_e        mode,
  input  logic             ser_up,
  input  logic             ser_dn,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q
);

  localparam int TOP = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic from_below;
    logic from_above;
    logic nxt;

    if (i == 0) begin : g_low_end
      assign from_below = ser_up;
    end else begin : g_low_mid
      assign from_below = q[i-1];
    end

    if (i == TOP) begin : g_high_end
      assign from_above = ser_dn;
    end else begin : g_high_mid
      assign from_above = q[i+1];
    end

    always_comb begin
      unique case (mode)
        MODE_UP:   nxt = from_below;
        MODE_DOWN: nxt = from_above;
        MODE_LOAD: nxt = par_in[i];
        default:   nxt = q[i];
      endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) q[i] <= 1'b0;
      else        q[i] <= nxt;
    end
  end

  // R1: contents are zero on the first edge after clear is released
  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(clr_n) |-> (q == '0));

  // R2
  p_hold_keeps_r2: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == MODE_HOLD) |=> $stable(q));

  // R3
  p_shift_up_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == MODE_UP) |=> (q == {$past(q[TOP-1:0]), $past(ser_up)}));

  // R4
  p_shift_down_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == MODE_DOWN) |=> (q == {$past(ser_dn), $past(q[TOP:1])}));

endmodule

// File: rtl/usr_pad_ctrl.sv
module usr_pad_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             drive_en,
  input  logic [WIDTH-1:0] q,
  inout  wire  [WIDTH-1:0] pad,
  output logic [WIDTH-1:0] pad_in
);

  assign pad    = drive_en ? q : {WIDTH{1'bz}};
  assign pad_in = pad;

endmodule

// File: rtl/usr_shift_bridge.sv
module usr_shift_bridge
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             sel_hi,
  input  logic             sel_lo,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic             ser_up_in,
  input  logic             ser_dn_in,
  inout  wire  [WIDTH-1:0] io_bus,
  output logic             q_lo,
  output logic             q_hi
);

  localparam int TOP = WIDTH - 1;

  usr_mode_e        mode;
  logic             drive_en;
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] pad_in;

  usr_mode_decode u_decode (
    .sel_hi   (sel_hi),
    .sel_lo   (sel_lo),
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .mode     (mode),
    .drive_en (drive_en)
  );

  usr_stage_array #(.WIDTH(WIDTH)) u_stages (
    .clk    (clk),
    .clr_n  (clr_n),
    .mode   (mode),
    .ser_up (ser_up_in),
    .ser_dn (ser_dn_in),
    .par_in (pad_in),
    .q      (q)
  );

  usr_pad_ctrl #(.WIDTH(WIDTH)) u_pads (
    .drive_en (drive_en),
    .q        (q),
    .pad      (io_bus),
    .pad_in   (pad_in)
  );

  assign q_lo = q[0];
  assign q_hi = q[TOP];

  // R5
  p_load_capture_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (sel_hi && sel_lo) |=> (q == $past(pad_in)));

  // R7
  p_disabled_release_r7: assert property (@(posedge clk) disable iff (!clr_n)
    (oe_a_n || oe_b_n) |-> !drive_en);

  // R8
  p_load_release_r8: assert property (@(posedge clk) disable iff (!clr_n)
    (sel_hi && sel_lo) |-> !drive_en);

endmodule

// File: tb/test_usr_shift_bridge.sv
module test_usr_shift_bridge;

  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic clr_n = 1'b0;
  logic sel_hi = 1'b0, sel_lo = 1'b0;
  logic oe_a_n = 1'b0, oe_b_n = 1'b0;
  logic ser_up = 1'b0, ser_dn = 1'b0;
  logic tb_en = 1'b0;
  logic [W-1:0] tb_d = '0;
  wire  [W-1:0] bus;
  logic q_lo, q_hi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign bus = tb_en ? tb_d : {W{1'bz}};

  always #4 clk = ~clk;

  usr_shift_bridge #(.WIDTH(W)) i_usr_shift_bridge (
    .clk       (clk),
    .clr_n     (clr_n),
    .sel_hi    (sel_hi),
    .sel_lo    (sel_lo),
    .oe_a_n    (oe_a_n),
    .oe_b_n    (oe_b_n),
    .ser_up_in (ser_up),
    .ser_dn_in (ser_dn),
    .io_bus    (bus),
    .q_lo      (q_lo),
    .q_hi      (q_hi)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input int m);
    sel_hi = m[1];
    sel_lo = m[0];
  endtask

  // Load v through the bus, then leave the block holding with pins driven.
  task automatic load_word(input int v);
    @(negedge clk);
    set_mode(3); tb_en = 1'b1; tb_d = v[W-1:0];
    @(posedge clk);
    @(negedge clk);
    set_mode(0); tb_en = 1'b0; oe_a_n = 1'b0; oe_b_n = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state, R1
    check("R1 reset bus", int'(bus), 0);
    check("R1 reset ends", int'({q_hi, q_lo}), 0);
    clr_n = 1'b1;

    // Exhaustive sweep: start value x mode x serial inputs
    for (int v = 0; v <= MASK; v++) begin
      for (int m = 0; m < 4; m++) begin
        for (int s = 0; s < 4; s++) begin
          int exp;
          load_word(v);
          check("R5 load", int'(bus), v);
          ser_up = s[0]; ser_dn = s[1];
          set_mode(m);
          tb_en = (m == 3);
          tb_d  = W'(~v);
          @(posedge clk);
          @(negedge clk);
          set_mode(0); tb_en = 1'b0;
          #1;
          case (m)
            0: exp = v;
            1: exp = ((v << 1) | s[0]) & MASK;
            2: exp = (v >> 1) | (s[1] << (W - 1));
            default: exp = (~v) & MASK;
          endcase
          case (m)
            0: check("R2 hold", int'(bus), exp);
            1: check("R3 shift up", int'(bus), exp);
            2: check("R4 shift down", int'(bus), exp);
            default: check("R5 load inverse", int'(bus), exp);
          endcase
          check("R9 serial ends", int'({q_hi, q_lo}), ((exp >> (W - 1)) << 1) | (exp & 1));
          check("R6 driven", int'(bus), exp);
        end
      end
    end

    // Release checks
    load_word(4'h9);
    oe_a_n = 1'b1; tb_en = 1'b1; tb_d = 4'h6; #1;
    check("R7 oe_a release", int'(bus), 6);
    check("R9 ends with oe off", int'({q_hi, q_lo}), 3);
    oe_a_n = 1'b0; oe_b_n = 1'b1; tb_d = 4'h5; #1;
    check("R7 oe_b release", int'(bus), 5);
    oe_b_n = 1'b0; set_mode(3); tb_d = 4'hA; #1;
    check("R8 load release", int'(bus), 10);
    @(posedge clk); @(negedge clk);
    set_mode(0); tb_en = 1'b0; #1;
    check("R5 load after release", int'(bus), 10);

    // Mid-cycle clear, no clock edge in between
    load_word(4'hF);
    #1 clr_n = 1'b0; #1;
    check("R1 async clear ends", int'({q_hi, q_lo}), 0);
    check("R1 async clear bus", int'(bus), 0);
    set_mode(3); tb_en = 1'b1; tb_d = 4'hF;
    @(posedge clk); @(negedge clk);
    set_mode(0); tb_en = 1'b0; #1;
    check("R1 clear beats load", int'(bus), 0);
    clr_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 stays zero", int'(bus), 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule